// File: doc/BRIEF.md
# Shared Set/Reset Line Generator with Per-Cell Storage

This block takes three product-term inputs and builds from them three shared asynchronous-style control lines for a group of programmable-logic cells. Line 0 always follows its product term. Lines 1 and 2 can each follow their product term or its inverse, which gives the sum-term form. Line 2 can also act as the latch enable for cells that are set up as transparent latches.

Each cell chooses one of the three lines, or none, with a 2-bit code. A per-cell polarity bit decides whether an active line forces the cell to 1 or to 0. As a result, one shared line can set one cell and clear another in the same cycle. Each cell is either an edge-triggered flip-flop or a latch. All timing is modelled on one system clock: the stored value is a register, and any set/reset that is active in a cycle wins over the data update of that cycle.

Top module: `srg_block`

## Requirements
- R1: Line 0 is active exactly when product term 0 is 1.
- R2: Line 1 is active when product term 1 is 1 while `inv_l1`=0, and when product term 1 is 0 while `inv_l1`=1.
- R3: Line 2 is active when product term 2 is 1 while `inv_l2`=0, and when product term 2 is 0 while `inv_l2`=1.
- R4: Each cell's 2-bit select field (bits 2i+1:2i of `cell_sel`) picks line 0, 1 or 2 with codes 0, 1 and 2. Code 3 means the cell takes no set/reset.
- R5: When a cell's selected line is active, the cell's next stored value is 1 if its `cell_set` bit is 1, and 0 if that bit is 0. The same line can set one cell and clear another in the same cycle.
- R6: A cell in flip-flop mode (`cell_latch` bit 0) with no active set/reset takes its `d` bit at each clock edge, so the new value appears on `q` one cycle later.
- R7: An active set/reset overrides the data update of a flip-flop cell in the same cycle.
- R8: A latch-mode cell takes `d` at the clock edge when its enable is high, and holds its value when the enable is low. The enable is line 2 while `le_sel` is 1, and it is constantly low while `le_sel` is 0.
- R9: An active set/reset overrides both latch update and latch hold.
- R10: While `le_sel` is 1, line 2 is not applied as set/reset to a latch-mode cell that selects it. A flip-flop cell that selects line 2 still receives it as set/reset.
- R11: While `rst_n` is low, every `q` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pt | input | 3 | Product-term inputs for lines 0 to 2 |
| inv_l1 | input | 1 | Line 1 uses the inverted product term |
| inv_l2 | input | 1 | Line 2 uses the inverted product term |
| le_sel | input | 1 | Line 2 serves as the latch enable |
| cell_sel | input | 2*NCELL | Per-cell line select, code 3 = none |
| cell_set | input | NCELL | Per-cell polarity: 1 sets, 0 clears |
| cell_latch | input | NCELL | Per-cell mode: 1 latch, 0 flip-flop |
| d | input | NCELL | Per-cell data |
| q | output | NCELL | Per-cell stored value |

## Verification
The stimulus targets these cases:
- Inverted line sources. A design that ignored `inv_l1` or `inv_l2` would set or clear cells on the wrong product-term level.
- Two cells that share one line with opposite polarity. A design that kept polarity per line would drive both cells the same way.
- Latch-mode cells that select line 2 while it is the enable. A design that did not mask it there would clear or set the cell every time the latch opens.
- Latch cells whose enable is off. These must hold through changing data, and a design that let data through would show it on `q` one cycle later.
- Code 3 cells under active lines. These must never be forced to either value.

// File: rtl/srg_pkg.sv
package srg_pkg;
    localparam int NLINE     = 3;
    localparam int SEL_W     = 2;
    localparam int LE_LINE   = 2;
    localparam logic [SEL_W-1:0] SEL_NONE = 2'd3;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             set_pol;
        logic             latch;
    } cell_cfg_t;

    typedef struct packed {
        logic q;
    } cell_state_t;
endpackage

// File: rtl/srg_lines.sv
module srg_lines
    import srg_pkg::*;
(
    input  logic [NLINE-1:0] pt,
    input  logic             inv_l1,
    input  logic             inv_l2,
    output logic [NLINE-1:0] line
);
    logic [NLINE-1:0] inv_mask;

    always_comb begin
        inv_mask    = '0;
        inv_mask[1] = inv_l1;
        inv_mask[2] = inv_l2;
    end

    for (genvar k = 0; k < NLINE; k++) begin : g_line
        assign line[k] = pt[k] ^ inv_mask[k];
    end
endmodule

// File: rtl/srg_cell.sv
module srg_cell
    import srg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NLINE-1:0] line,
    input  logic             le_sel,
    input  cell_cfg_t        cfg,
    input  logic             d,
    output logic             q
);
    cell_state_t state_d, state_q;
    logic        line_val;
    logic        sr_hit;
    logic        latch_en;

    always_comb begin
        line_val = 1'b0;
        if (cfg.sel != SEL_NONE) line_val = line[cfg.sel];
        sr_hit   = line_val
                 && !(cfg.latch && le_sel && cfg.sel == SEL_W'(LE_LINE));
        latch_en = le_sel && line[LE_LINE];

        state_d = state_q;
        if (sr_hit)          state_d.q = cfg.set_pol;
        else if (!cfg.latch) state_d.q = d;
        else if (latch_en)   state_d.q = d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign q = state_q.q;

    AST_SET_FORCES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.sel != SEL_NONE && line[cfg.sel] && cfg.set_pol && !cfg.latch) |=> q); // R5

    AST_CLEAR_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.sel != SEL_NONE && line[cfg.sel] && !cfg.set_pol && !cfg.latch) |=> !q); // R7

    AST_NONE_TAKES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.sel == SEL_NONE && !cfg.latch) |=> q == $past(d)); // R4

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.latch && !le_sel && cfg.sel == SEL_NONE) |=> q == $past(q)); // R8

    AST_LE_LINE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.latch && le_sel && cfg.sel == SEL_W'(LE_LINE) && line[LE_LINE]) |=> q == $past(d)); // R10
endmodule

// File: rtl/srg_block.sv
module srg_block
    import srg_pkg::*;
#(
    parameter int NCELL = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NLINE-1:0]   pt,
    input  logic               inv_l1,
    input  logic               inv_l2,
    input  logic               le_sel,
    input  logic [SEL_W*NCELL-1:0] cell_sel,
    input  logic [NCELL-1:0]   cell_set,
    input  logic [NCELL-1:0]   cell_latch,
    input  logic [NCELL-1:0]   d,
    output logic [NCELL-1:0]   q
);
    logic [NLINE-1:0] line;

    srg_lines i_lines (
        .pt     (pt),
        .inv_l1 (inv_l1),
        .inv_l2 (inv_l2),
        .line   (line)
    );

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        cell_cfg_t cfg;
        always_comb begin
            cfg.sel     = cell_sel[SEL_W*i +: SEL_W];
            cfg.set_pol = cell_set[i];
            cfg.latch   = cell_latch[i];
        end

        srg_cell i_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .line   (line),
            .le_sel (le_sel),
            .cfg    (cfg),
            .d      (d[i]),
            .q      (q[i])
        );
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> q == '0); // R11

    AST_LINE0_NONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pt[0] && cell_sel[1:0] == 2'd0 && !cell_latch[0]) |=> q[0] == $past(d[0])); // R1
endmodule

// File: tb/test_srg_block.sv
module test_srg_block;
    localparam int NCELL = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [2:0]         pt = '0;
    logic               inv_l1 = 1'b0;
    logic               inv_l2 = 1'b0;
    logic               le_sel = 1'b0;
    logic [2*NCELL-1:0] cell_sel = '1;
    logic [NCELL-1:0]   cell_set = '0;
    logic [NCELL-1:0]   cell_latch = '0;
    logic [NCELL-1:0]   d = '0;
    logic [NCELL-1:0]   q;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [NCELL-1:0] exp_q = '0;
    string            tag [NCELL];

    srg_block #(.NCELL(NCELL)) i_srg_block (
        .clk(clk), .rst_n(rst_n), .pt(pt), .inv_l1(inv_l1), .inv_l2(inv_l2),
        .le_sel(le_sel), .cell_sel(cell_sel), .cell_set(cell_set),
        .cell_latch(cell_latch), .d(d), .q(q)
    );

    always #4 clk = ~clk;

    function automatic bit line_of(int k);
        case (k)
            0: return pt[0];                 // R1
            1: return inv_l1 ? !pt[1] : pt[1]; // R2
            default: return inv_l2 ? !pt[2] : pt[2]; // R3
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_q = '0;
            for (int i = 0; i < NCELL; i++) tag[i] = "R11";
        end else begin
            for (int i = 0; i < NCELL; i++) begin
                int  k;
                bit  hit;
                k   = int'(cell_sel[2*i +: 2]);
                hit = 0;
                if (k < 3) begin
                    hit = line_of(k);
                    if (k == 2 && le_sel && cell_latch[i]) hit = 0;
                end
                if (hit) begin
                    exp_q[i] = cell_set[i];
                    tag[i] = cell_latch[i] ? "R9 R5" : "R7 R5";
                end else if (!cell_latch[i]) begin
                    exp_q[i] = d[i];
                    tag[i] = (k == 3) ? "R4 R6" : "R6";
                end else begin
                    if (le_sel && line_of(2)) exp_q[i] = d[i];
                    tag[i] = (k == 2 && le_sel) ? "R10 R8" : "R8";
                end
            end
        end
    end

    task automatic compare();
        for (int i = 0; i < NCELL; i++) begin
            checks++;
            if (q[i] !== exp_q[i]) begin
                errors++;
                $display("FAIL %s cell %0d: q=%b expected=%b", tag[i], i, q[i], exp_q[i]);
            end
        end
    endtask

    task automatic run_phase(int n, int mode);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            compare();
            pt = 3'($urandom);
            d  = NCELL'($urandom);
            if (mode == 5) begin
                inv_l1 = 1'($urandom); inv_l2 = 1'($urandom); le_sel = 1'($urandom);
                cell_sel = (2*NCELL)'($urandom); cell_set = NCELL'($urandom);
                cell_latch = NCELL'($urandom);
            end else if (c % 16 == 0) begin
                cell_sel = (2*NCELL)'($urandom);
                cell_set = NCELL'($urandom);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare();                          // R11 reset state
        rst_n = 1'b1;
        // flip-flop cells, true product terms
        inv_l1 = 0; inv_l2 = 0; le_sel = 0; cell_latch = '0;
        run_phase(300, 0);
        // inverted sources on lines 1 and 2 (R2, R3)
        inv_l1 = 1; inv_l2 = 1;
        run_phase(300, 1);
        // one line sets one cell and clears another (R5)
        @(negedge clk);
        compare();
        cell_sel = {2'd3, 2'd3, 2'd1, 2'd1};
        cell_set = 4'b0001;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            compare();
            pt = 3'($urandom); d = NCELL'($urandom);
        end
        // latch cells with line 2 as enable (R8, R9, R10)
        inv_l2 = 0; le_sel = 1; cell_latch = '1;
        run_phase(300, 2);
        // latch cells with enable off: hold (R8)
        le_sel = 0;
        cell_sel = '1;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            compare();
            pt = 3'($urandom); d = NCELL'($urandom);
        end
        run_phase(200, 3);
        // mixed modes
        cell_latch = 4'b1010; le_sel = 1; inv_l2 = 1;
        run_phase(300, 4);
        run_phase(1000, 5);
        // reset mid-run (R11)
        @(negedge clk);
        compare();
        rst_n = 0;
        #1;
        compare();
        @(negedge clk);
        rst_n = 1;
        run_phase(50, 5);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule